// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block sits above a single analog-to-digital conversion controller and runs it through a set of input channels without software help. A channel mask selects which inputs take part. When a scan trigger arrives, the sequencer walks the enabled channels from the lowest index upwards. For each one it holds an acquisition window, then pulses a start request to the converter, waits for the converter's done strobe and stores the returned sample in the next result slot. The acquisition window is programmed in whole TAD units, where one TAD is a fixed number of system clocks set by a parameter. The time spent on one channel is therefore the acquisition window plus the converter's own latency.

The trigger comes from one of two places. It can be an external pulse, or it can come from a built-in rate timer that fires every `rate_period`+1 clocks. Each scan starts again at slot 0 and at the lowest enabled channel, so older results are overwritten. A per-slot unread bit, a sticky overrun flag and a sticky missed-trigger flag tell software whether data was lost. A read strobe returns one slot. It clears that slot's unread bit and both sticky flags. A one-cycle `scan_irq` pulse marks the end of each scan.

The controller has five states. `SQ_IDLE` means the mask is empty. `SQ_ARMED` waits for a trigger. `SQ_ACQ` counts the acquisition window. `SQ_START` drives the start pulse. `SQ_CONV` waits for done. The transitions are:
- idle-to-armed when the mask becomes non-zero.
- armed-to-idle when the mask becomes empty.
- armed-to-acquire on a trigger; the mask is latched at this point.
- acquire-to-start when the window has elapsed.
- start-to-convert unconditionally.
- convert-to-acquire on done when a higher enabled channel remains.
- convert-to-armed on done after the last enabled channel.

Top module: `adc_scan_seq`

## Requirements
- R1: While `chan_en` is all zero the sequencer stays idle: triggers start no conversion, `busy` stays low and `missed` is not set.
- R2: After a trigger, exactly the channels enabled in the mask latched at that trigger are converted, each once, in ascending channel index; `conv_chan` holds the channel number during `conv_start`.
- R3: The k-th conversion of a scan (k counted from 0) is stored in slot k, and `rd_data` shows the contents of the slot addressed by `rd_slot` in the same cycle.
- R4: `conv_start` is a one-cycle pulse. It rises exactly `acq_tad`*TAD_DIV+1 clocks after the clock edge that samples the accepted trigger, or the done strobe of the previous channel in the same scan.
- R5: Every scan restarts at slot 0 and the lowest enabled channel, overwriting the earlier contents.
- R6: Writing a slot whose unread bit is set raises `overrun`. A cycle with `rd_en` high clears `overrun` and the unread bit of slot `rd_slot`. Every write sets that slot's unread bit.
- R7: `scan_irq` is a single-cycle pulse in the cycle after the done strobe of the last enabled channel, once per scan.
- R8: A trigger that arrives while `busy` is high is dropped without disturbing the running scan and sets `missed`; `rd_en` clears `missed`.
- R9: With `trig_sel`=0 the trigger is `ext_trig`. With `trig_sel`=1 the internal timer fires every `rate_period`+1 clocks while the mask is non-zero, and `ext_trig` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | NCH | Channel enable mask, bit i = channel i |
| acq_tad | input | ACQW | Acquisition window in TAD units |
| trig_sel | input | 1 | 0 = external trigger, 1 = internal rate timer |
| ext_trig | input | 1 | External trigger pulse |
| rate_period | input | RW | Internal timer interval minus one, in clocks |
| conv_start | output | 1 | One-cycle conversion request to the converter |
| conv_chan | output | log2(NCH) | Channel being acquired or converted |
| conv_done | input | 1 | Converter done strobe, one cycle |
| conv_data | input | DW | Converter result, valid with conv_done |
| rd_en | input | 1 | Read strobe: clears the slot's unread bit and the sticky flags |
| rd_slot | input | log2(NCH) | Slot to read |
| rd_data | output | DW | Contents of slot rd_slot |
| slot_unread | output | NCH | Per-slot unread bits |
| busy | output | 1 | Scan in progress |
| overrun | output | 1 | Sticky: an unread slot was overwritten |
| missed | output | 1 | Sticky: a trigger was dropped during a scan |
| scan_irq | output | 1 | Scan-complete pulse |

## Verification
The bound checker enforces the following on every clock:
- the start pulse lasts one cycle and always names a latched enabled channel;
- an empty mask never leads into a scan;
- a trigger during a scan sets the missed flag;
- writing an unread slot sets the overrun flag;
- the completion pulse lasts one cycle and always follows a done strobe.

Some behaviours can only be shown by the bench scenarios, which compare against a converter model:
- that the ascending channel order is correct;
- the exact acquisition delay in clocks for random TAD settings;
- the mapping of conversions to slots, and the wrap onto slot 0;
- the interval of the internal timer;
- that a dropped trigger leaves the running scan intact.

// File: rtl/adcscan_pkg.sv
package adcscan_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ARMED,
        SQ_ACQ,
        SQ_START,
        SQ_CONV
    } sq_state_t;
endpackage

// File: rtl/scan_tad_div.sv
module scan_tad_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/scan_rate_timer.sv
module scan_rate_timer #(
    parameter int RW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [RW-1:0] period,
    output logic          fire
);
    logic [RW-1:0] cnt;

    assign fire = run && (cnt == period);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (fire)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/scan_result_buf.sv
module scan_result_buf #(
    parameter int NSLOT = 4,
    parameter int DW    = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NSLOT)-1:0] wr_slot,
    input  logic [DW-1:0]            wr_data,
    input  logic                     rd_en,
    input  logic [$clog2(NSLOT)-1:0] rd_slot,
    output logic [DW-1:0]            rd_data,
    output logic [NSLOT-1:0]         unread,
    output logic                     overrun
);
    logic [DW-1:0] mem [NSLOT];

    assign rd_data = mem[rd_slot];

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[s]    <= '0;
                    unread[s] <= 1'b0;
                end else if (wr_en && (int'(wr_slot) == s)) begin
                    mem[s]    <= wr_data;
                    unread[s] <= 1'b1;
                end else if (rd_en && (int'(rd_slot) == s)) begin
                    unread[s] <= 1'b0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)                        overrun <= 1'b0;
        else if (wr_en && unread[wr_slot]) overrun <= 1'b1;
        else if (rd_en)                    overrun <= 1'b0;
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adcscan_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int DW      = 10,
    parameter int ACQW    = 4,
    parameter int RW      = 12,
    parameter int TAD_DIV = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         chan_en,
    input  logic [ACQW-1:0]        acq_tad,
    input  logic                   trig_sel,
    input  logic                   ext_trig,
    input  logic [RW-1:0]          rate_period,
    output logic                   conv_start,
    output logic [$clog2(NCH)-1:0] conv_chan,
    input  logic                   conv_done,
    input  logic [DW-1:0]          conv_data,
    input  logic                   rd_en,
    input  logic [$clog2(NCH)-1:0] rd_slot,
    output logic [DW-1:0]          rd_data,
    output logic [NCH-1:0]         slot_unread,
    output logic                   busy,
    output logic                   overrun,
    output logic                   missed,
    output logic                   scan_irq
);
    localparam int CHW = $clog2(NCH);

    sq_state_t       state, state_nx;
    logic [NCH-1:0]  mask_q;
    logic [CHW-1:0]  cur_ch, slot, first_ch, nxt_ch;
    logic            has_next;
    logic [ACQW-1:0] acq_cnt;
    logic            tad_tick, rate_fire, trig, wr_en, acq_over;

    scan_tad_div #(.DIV(TAD_DIV)) u_tad (
        .clk(clk), .rst_n(rst_n), .clr(state != SQ_ACQ), .tick(tad_tick)
    );

    scan_rate_timer #(.RW(RW)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(trig_sel && (state != SQ_IDLE)),
        .period(rate_period), .fire(rate_fire)
    );

    scan_result_buf #(.NSLOT(NCH), .DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(slot),
        .wr_data(conv_data), .rd_en(rd_en), .rd_slot(rd_slot),
        .rd_data(rd_data), .unread(slot_unread), .overrun(overrun)
    );

    assign trig     = trig_sel ? rate_fire : ext_trig;
    assign acq_over = (acq_cnt == acq_tad);

    // lowest enabled channel of the live mask, next higher of the latched mask
    always_comb begin
        first_ch = '0;
        nxt_ch   = '0;
        has_next = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (chan_en[i]) first_ch = CHW'(i);
            if (mask_q[i] && (i > int'(cur_ch))) begin
                nxt_ch   = CHW'(i);
                has_next = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:  if (chan_en != '0) state_nx = SQ_ARMED;
            SQ_ARMED: begin
                if (chan_en == '0) state_nx = SQ_IDLE;
                else if (trig)     state_nx = SQ_ACQ;
            end
            SQ_ACQ:   if (acq_over) state_nx = SQ_START;
            SQ_START: state_nx = SQ_CONV;
            SQ_CONV:  if (conv_done) state_nx = has_next ? SQ_ACQ : SQ_ARMED;
            default:  state_nx = SQ_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        conv_start = (state == SQ_START);
        busy       = (state == SQ_ACQ) || (state == SQ_START) || (state == SQ_CONV);
        wr_en      = (state == SQ_CONV) && conv_done;
        conv_chan  = cur_ch;
    end

    // scan datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            cur_ch   <= '0;
            slot     <= '0;
            acq_cnt  <= '0;
            scan_irq <= 1'b0;
            missed   <= 1'b0;
        end else begin
            scan_irq <= wr_en && !has_next;
            if (busy && trig)  missed <= 1'b1;
            else if (rd_en)    missed <= 1'b0;
            if (state == SQ_ARMED && chan_en != '0 && trig) begin
                mask_q  <= chan_en;
                cur_ch  <= first_ch;
                slot    <= '0;
                acq_cnt <= '0;
            end else if (state == SQ_ACQ && tad_tick && !acq_over) begin
                acq_cnt <= acq_cnt + 1'b1;
            end else if (wr_en && has_next) begin
                cur_ch  <= nxt_ch;
                slot    <= slot + 1'b1;
                acq_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
    parameter int NCH = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   conv_start,
    input logic [$clog2(NCH)-1:0] conv_chan,
    input logic                   conv_done,
    input logic                   scan_irq,
    input logic                   busy,
    input logic [NCH-1:0]         chan_en,
    input logic [NCH-1:0]         mask_q,
    input logic                   trig,
    input logic                   missed,
    input logic                   overrun,
    input logic                   wr_en,
    input logic [$clog2(NCH)-1:0] wr_slot,
    input logic [NCH-1:0]         unread
);
    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R2
    start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> mask_q[conv_chan]);
    // R1
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && chan_en == '0) |=> !busy);
    // R8
    missed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trig) |=> missed);
    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unread[wr_slot]) |=> overrun);
    // R7
    irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_irq |-> $past(conv_done));
    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_irq |=> !scan_irq);
endmodule

bind adc_scan_seq scan_seq_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .scan_irq(scan_irq), .busy(busy), .chan_en(chan_en),
    .mask_q(mask_q), .trig(trig), .missed(missed), .overrun(overrun),
    .wr_en(wr_en), .wr_slot(slot), .unread(slot_unread)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4, DW = 10, ACQW = 4, RW = 12, TAD_DIV = 4;

    logic clk = 0, rst_n = 0;
    logic [NCH-1:0] chan_en = '0;
    logic [ACQW-1:0] acq_tad = '0;
    logic trig_sel = 0, ext_trig = 0, conv_done = 0, rd_en = 0;
    logic [RW-1:0] rate_period = '0;
    logic [DW-1:0] conv_data = '0;
    logic [1:0] rd_slot = '0;
    logic conv_start, busy, overrun, missed, scan_irq;
    logic [1:0] conv_chan;
    logic [DW-1:0] rd_data;
    logic [NCH-1:0] slot_unread;

    adc_scan_seq #(.NCH(NCH), .DW(DW), .ACQW(ACQW), .RW(RW), .TAD_DIV(TAD_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .acq_tad(acq_tad),
        .trig_sel(trig_sel), .ext_trig(ext_trig), .rate_period(rate_period),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_data(conv_data), .rd_en(rd_en), .rd_slot(rd_slot), .rd_data(rd_data),
        .slot_unread(slot_unread), .busy(busy), .overrun(overrun), .missed(missed),
        .scan_irq(scan_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, failures = 0;
    int logn = 0, seqn = 0, clat = 1, irqn = 0, irqt = 0;
    int logc [64], logt [64], logd [64], logv [64];

    task automatic chk(string req, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_data(int ch, int sq);
        return (ch * 97 + sq * 13 + 5) % 1024;
    endfunction

    function automatic int popc(logic [NCH-1:0] m);
        int n = 0;
        for (int i = 0; i < NCH; i++) n += int'(m[i]);
        return n;
    endfunction

    // converter model
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                if (logn < 64) begin
                    logc[logn] = int'(conv_chan);
                    logt[logn] = cyc;
                end
                repeat (clat) @(negedge clk);
                conv_data = DW'(model_data(int'(conv_chan), seqn));
                conv_done = 1;
                if (logn < 64) begin
                    logd[logn] = cyc;
                    logv[logn] = int'(conv_data);
                end
                logn++;
                seqn++;
                @(negedge clk);
                conv_done = 0;
            end
        end
    end

    always @(negedge clk) if (scan_irq) begin irqn++; irqt = cyc; end

    task automatic run_scan(logic [NCH-1:0] m, int acq, int lat, int poke);
        int k, exp_ch [NCH], n;
        chan_en = m; acq_tad = ACQW'(acq); clat = lat;
        @(negedge clk);
        logn = 0; irqn = 0;
        ext_trig = 1;
        k = cyc;
        @(negedge clk) ext_trig = 0;
        for (int w = 0; w < 2000 && irqn == 0; w++) begin
            if (poke > 0 && w == poke) ext_trig = 1;
            else ext_trig = 0;
            @(negedge clk);
        end
        ext_trig = 0;
        repeat (2) @(negedge clk);
        n = 0;
        for (int c = 0; c < NCH; c++) if (m[c]) begin exp_ch[n] = c; n++; end
        chk("R2 conversion count", logn == n, logn, n);
        for (int i = 0; i < n && i < logn; i++) begin
            int t_ref = (i == 0) ? k : logd[i-1];
            chk("R2 channel order", logc[i] == exp_ch[i], logc[i], exp_ch[i]);
            chk("R4 acquisition delay", logt[i] == t_ref + acq * TAD_DIV + 2,
                logt[i] - t_ref, acq * TAD_DIV + 2);
        end
        chk("R7 one irq per scan", irqn == 1, irqn, 1);
        if (logn > 0)
            chk("R7 irq timing", irqt == logd[logn-1] + 1, irqt, logd[logn-1] + 1);
    endtask

    task automatic verify_buf(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_slot = 2'(i);
            #1;
            chk("R3 R5 slot contents", int'(rd_data) == logv[i], int'(rd_data), logv[i]);
            rd_en = 1;
            @(negedge clk);
            rd_en = 0;
        end
        @(negedge clk);
        chk("R6 overrun cleared by read", overrun == 0, int'(overrun), 0);
        chk("R8 missed cleared by read", missed == 0, int'(missed), 0);
        chk("R6 unread bits cleared", slot_unread == '0, int'(slot_unread), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset busy", busy == 0, int'(busy), 0);
        chk("R4 reset start", conv_start == 0, int'(conv_start), 0);
        chk("R7 reset irq", scan_irq == 0, int'(scan_irq), 0);
        chk("R6 reset overrun", overrun == 0 && slot_unread == '0, int'(overrun), 0);

        // R1: empty mask ignores triggers
        logn = 0;
        for (int p = 0; p < 3; p++) begin
            ext_trig = 1; @(negedge clk); ext_trig = 0;
            repeat (9) @(negedge clk);
            chk("R1 idle not busy", busy == 0, int'(busy), 0);
        end
        chk("R1 no conversion", logn == 0, logn, 0);
        chk("R1 no missed", missed == 0, int'(missed), 0);

        // directed sparse mask
        run_scan(4'b1010, 2, 3, 0);
        verify_buf(2);
        run_scan(4'b1111, 0, 1, 0);
        verify_buf(4);

        // R8: trigger during scan
        run_scan(4'b0110, 7, 4, 5);
        chk("R8 missed set", missed == 1, int'(missed), 1);
        verify_buf(2);

        // R5/R6: second scan overwrites unread data
        run_scan(4'b1001, 1, 1, 0);
        chk("R6 no overrun first pass", overrun == 0, int'(overrun), 0);
        chk("R6 unread after first pass", slot_unread == 4'b0011, int'(slot_unread), 3);
        run_scan(4'b1001, 1, 2, 0);
        chk("R6 overrun set", overrun == 1, int'(overrun), 1);
        verify_buf(2);

        // random scans
        for (int it = 0; it < 12; it++) begin
            logic [NCH-1:0] m;
            m = NCH'($urandom_range(1, 15));
            run_scan(m, $urandom_range(0, 6), $urandom_range(1, 4), 0);
            verify_buf(popc(m));
        end

        // R9: internal rate timer
        chan_en = 4'b0100; acq_tad = '0; clat = 2; rate_period = 12'd40;
        @(negedge clk);
        logn = 0;
        trig_sel = 1;
        for (int w = 0; w < 1000 && logn < 3; w++) begin
            ext_trig = (w % 7 == 3);
            @(negedge clk);
        end
        ext_trig = 0;
        chk("R9 timer scans", logn >= 3, logn, 3);
        chk("R9 interval 1", logt[1] - logt[0] == 41, logt[1] - logt[0], 41);
        chk("R9 interval 2", logt[2] - logt[1] == 41, logt[2] - logt[1], 41);
        chk("R9 ext ignored no missed", missed == 0, int'(missed), 0);
        trig_sel = 0;
        for (int w = 0; w < 100 && busy; w++) @(negedge clk);
        @(negedge clk);
        rd_slot = 2'd0;
        #1;
        chk("R9 R5 slot0 latest", int'(rd_data) == logv[logn-1], int'(rd_data), logv[logn-1]);
        rd_en = 1; @(negedge clk); rd_en = 0;
        @(negedge clk);
        chk("R6 overrun cleared", overrun == 0, int'(overrun), 0);

        // R1: clearing the mask returns to idle
        chan_en = '0;
        repeat (2) @(negedge clk);
        logn = 0;
        ext_trig = 1; @(negedge clk); ext_trig = 0;
        repeat (20) @(negedge clk);
        chk("R1 mask cleared no scan", logn == 0 && busy == 0, logn, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule